// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Status

This block is the buffering half of a serial receiver. A bit-recovery stage upstream hands over each finished character with its raw data bits, its first stop bit and the parity bit it sampled. A separate strobe marks each new start bit. The block keeps a small queue of finished characters, two by default, and one more character in a holding slot that stands in for the shift stage. Each stored character carries its own frame, parity and overrun flags. Software reads the head character through a read port, and a read of the low data byte removes that character.

Status is worked out once, when a character enters the holding slot. The data bits above the selected character size are cleared. The parity check follows the parity mode in force at that moment. The frame flag is the inverse of the stop bit. An overrun happens when a start bit is detected while the queue is full and the holding slot is also occupied. It marks the character that next reaches the head. Dropping the receiver enable empties the queue and the holding slot and discards any pending overrun.

Top module: `rx_char_fifo`

## Requirements
- R1: The queue holds up to DEPTH characters (default 2) in arrival order. One character is removed only on a clock edge where `rd_low` is high, `rx_enable` is high and the queue is not empty. `rd_low` on an empty queue changes nothing.
- R2: `rx_done` is high exactly when the queue holds at least one character. It is low after reset.
- R3: `err_frame` of the head character is the inverse of the stop bit that character arrived with.
- R4: `par_mode` selects the parity check: 2'b00 means off, 2'b01 is reserved and also means off, 2'b10 means even and 2'b11 means odd. Let X be the XOR of the kept data bits and the received parity bit. `err_parity` is X in even mode, NOT X in odd mode, and 0 when the check is off. The mode in use is the one present on the cycle the character is accepted.
- R5: A `start_seen` pulse marks an overrun when three conditions hold: the queue is full, the holding slot is occupied, and no read happens in that cycle. On the next read, the character that becomes the new head shows `err_overrun`=1. A character that arrives while the holding slot is occupied and cannot drain is lost.
- R6: While `rx_enable` is low, the queue, the holding slot and any pending overrun are cleared on every edge, and incoming characters are ignored. `rx_done` and all error flags read 0 one cycle later.
- R7: `size_code` sets the kept data bits: 0→5, 1→6, 2→7, 3→8, 7→9, and 4..6 are reserved and mean 8. Bits above the kept size read as zero, so `rd_bit8` is 0 in every mode except 9-bit.
- R8: While the head is not removed, `rd_data`, `rd_bit8`, `err_frame` and `err_parity` hold steady. The ninth bit therefore stays readable until the low-byte read removes the character.
- R9: A character is accepted into the holding slot on the edge where `char_valid` is high. It moves into the queue on the first later edge that finds the queue not full. With free space, `rx_done` rises two edges after `char_valid` is sampled.
- R10: With the queue empty, `rd_data`, `rd_bit8` and all three error flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low flushes all state |
| char_valid | input | 1 | One-cycle strobe: a finished character is presented |
| char_bits | input | 9 | Raw received data bits, bit 0 first received |
| char_stop | input | 1 | Sampled first stop bit |
| char_parity | input | 1 | Sampled parity bit |
| start_seen | input | 1 | Strobe: a new start bit was detected |
| size_code | input | 3 | Character size selection (see R7) |
| par_mode | input | 2 | Parity check mode (see R4) |
| rd_low | input | 1 | Read of the low data byte; removes the head |
| rx_done | output | 1 | Unread data present |
| rd_data | output | 8 | Low eight data bits of the head character |
| rd_bit8 | output | 1 | Ninth data bit of the head character |
| err_frame | output | 1 | Frame error of the head character |
| err_parity | output | 1 | Parity error of the head character |
| err_overrun | output | 1 | Overrun marked on the head character |

## Verification
The queue, the holding slot and the pending-overrun mark all surface at the head through the read port. A slot that shifts wrongly, a level count that drifts, or a mark placed on the wrong entry therefore shows up as a wrong `rx_done`, wrong data or a wrong error flag. This appears on the first clock after the edge that corrupted it, once the head is read. The reference model tracks the queue contents, the holding slot and the pending mark on every edge. Outputs are compared in every cycle, so a fault shows up no later than the read that exposes it. Directed sequences fill the queue, the holding slot and the overrun path, and a random phase mixes reads, start strobes and enable drops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int CHAR_W = 9;

   typedef enum logic [1:0] {
      PAR_OFF  = 2'b00,
      PAR_RSV  = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              fe;
      logic              pe;
      logic              dor;
   } rxq_ent_t;

endpackage

// File: rtl/rxq_capture.sv
// Turns a raw finished character into a stored entry: masks unused bits,
// evaluates parity under the current mode, records the frame error.
module rxq_capture
   import rxq_pkg::*;
(
   input  logic [CHAR_W-1:0] raw_bits,
   input  logic              stop_bit,
   input  logic              par_bit,
   input  logic [2:0]        size_code,
   input  logic [1:0]        par_mode,
   output rxq_ent_t          ent
);

   logic [3:0]        n_keep;
   logic [CHAR_W-1:0] keep;
   logic [CHAR_W-1:0] kept;
   logic              par_x;

   always_comb begin
      case (size_code)
         3'd0:    n_keep = 4'd5;
         3'd1:    n_keep = 4'd6;
         3'd2:    n_keep = 4'd7;
         3'd7:    n_keep = 4'd9;
         default: n_keep = 4'd8;
      endcase
   end

   for (genvar b = 0; b < CHAR_W; b++) begin : g_keep
      assign keep[b] = (4'(b) < n_keep);
   end

   assign kept  = raw_bits & keep;
   assign par_x = (^kept) ^ par_bit;

   always_comb begin
      ent.data = kept;
      ent.fe   = ~stop_bit;
      ent.dor  = 1'b0;
      case (par_mode_e'(par_mode))
         PAR_EVEN: ent.pe = par_x;
         PAR_ODD:  ent.pe = ~par_x;
         default:  ent.pe = 1'b0;
      endcase
   end

endmodule

// File: rtl/rxq_hold.sv
// Holding slot standing in for the shift stage, plus the pending overrun mark.
module rxq_hold
   import rxq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flush,
   input  logic     in_valid,
   input  rxq_ent_t in_ent,
   input  logic     start_seen,
   input  logic     fifo_full,
   input  logic     fifo_popping,
   output logic     hold_v,
   output rxq_ent_t hold_ent,
   output logic     move,
   output logic     ovr_pend
);

   logic accept;
   logic ovr_set;

   assign move    = hold_v && !fifo_full;
   assign accept  = in_valid && (!hold_v || move);
   assign ovr_set = start_seen && fifo_full && hold_v && !fifo_popping;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v   <= 1'b0;
         hold_ent <= '0;
         ovr_pend <= 1'b0;
      end else if (flush) begin
         hold_v   <= 1'b0;
         hold_ent <= '0;
         ovr_pend <= 1'b0;
      end else begin
         hold_v   <= accept || (hold_v && !move);
         if (accept) hold_ent <= in_ent;
         ovr_pend <= (ovr_pend && !fifo_popping) || ovr_set;
      end
   end

   // R5: a pending overrun only exists while queue and holding slot are both occupied
   assert_ovr_context_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_pend |-> (fifo_full && hold_v));

   // R9: a held character that cannot drain stays held
   assert_hold_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && fifo_full && !flush && !fifo_popping) |=> hold_v);

endmodule

// File: rtl/rxq_store.sv
// Shift-register queue: slot 0 is always the head.
module rxq_store
   import rxq_pkg::*;
#(
   parameter  int DEPTH = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  rxq_ent_t         push_ent,
   input  logic             pop,
   input  logic             mark_dor,
   output rxq_ent_t         head,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_store: DEPTH must be at least 2");
   end

   rxq_ent_t         slot_q [DEPTH];
   logic             do_pop;
   logic             do_push;
   logic [CNT_W-1:0] wr_idx;

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && !full;
   assign wr_idx  = do_pop ? level - 1'b1 : level;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rxq_ent_t cur_r;
      rxq_ent_t nxt;
      rxq_ent_t above;

      if (i + 1 < DEPTH) begin : g_mid
         assign above = slot_q[i+1];
      end else begin : g_top
         assign above = '0;
      end

      always_comb begin
         nxt = cur_r;
         if (do_pop) nxt = above;
         if (do_push && (wr_idx == CNT_W'(i))) nxt = push_ent;
         if ((i == 0) && do_pop && mark_dor) nxt.dor = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cur_r <= '0;
         else if (flush) cur_r <= '0;
         else            cur_r <= nxt;
      end

      assign slot_q[i] = cur_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     level <= '0;
      else if (flush) level <= '0;
      else            level <= level + CNT_W'(do_push) - CNT_W'(do_pop);
   end

   assign head = slot_q[0];

   // R1: occupancy never exceeds the configured depth
   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   // R1: a lone removal lowers the occupancy by one
   assert_pop_lowers_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && !do_push && !flush) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_enable,
   input  logic       char_valid,
   input  logic [8:0] char_bits,
   input  logic       char_stop,
   input  logic       char_parity,
   input  logic       start_seen,
   input  logic [2:0] size_code,
   input  logic [1:0] par_mode,
   input  logic       rd_low,
   output logic       rx_done,
   output logic [7:0] rd_data,
   output logic       rd_bit8,
   output logic       err_frame,
   output logic       err_parity,
   output logic       err_overrun
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (CHAR_W != 9) begin : g_bad_width
      $error("rx_char_fifo: port widths assume nine data bits");
   end

   rxq_ent_t         cap_ent;
   rxq_ent_t         hold_ent;
   rxq_ent_t         head;
   logic             hold_v;
   logic             move;
   logic             ovr_pend;
   logic             flush;
   logic             pop_req;
   logic             q_full;
   logic             q_empty;
   logic [CNT_W-1:0] q_level;

   assign flush   = !rx_enable;
   assign pop_req = rd_low && rx_enable;

   rxq_capture i_capture (
      .raw_bits  (char_bits),
      .stop_bit  (char_stop),
      .par_bit   (char_parity),
      .size_code (size_code),
      .par_mode  (par_mode),
      .ent       (cap_ent)
   );

   rxq_hold i_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .in_valid     (char_valid),
      .in_ent       (cap_ent),
      .start_seen   (start_seen),
      .fifo_full    (q_full),
      .fifo_popping (pop_req && !q_empty),
      .hold_v       (hold_v),
      .hold_ent     (hold_ent),
      .move         (move),
      .ovr_pend     (ovr_pend)
   );

   rxq_store #(.DEPTH(DEPTH)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (move),
      .push_ent (hold_ent),
      .pop      (pop_req),
      .mark_dor (ovr_pend),
      .head     (head),
      .level    (q_level),
      .full     (q_full),
      .empty    (q_empty)
   );

   assign rx_done     = !q_empty;
   assign rd_data     = q_empty ? 8'h00 : head.data[7:0];
   assign rd_bit8     = !q_empty && head.data[8];
   assign err_frame   = !q_empty && head.fe;
   assign err_parity  = !q_empty && head.pe;
   assign err_overrun = !q_empty && head.dor;

   // R1: unread data does not vanish without a read
   assert_keep_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && rx_done && !rd_low) |=> rx_done);

   // R6: a disabled receiver leaves nothing readable
   assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (!rx_done && !err_overrun && !err_frame && !err_parity));

   // R7: the ninth bit is cleared outside 9-bit mode
   assert_ninth_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && size_code != 3'd7) |-> !cap_ent.data[8]);

   // R8: head contents hold until the low byte is read
   assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_enable && rx_done && !rd_low) |=>
         ($stable(rd_data) && $stable(rd_bit8) && $stable(err_frame) && $stable(err_parity)));

endmodule

// File: tb/test_rx_char_fifo.sv
module test_rx_char_fifo;

   localparam int DEPTH = 2;

   typedef struct packed {
      logic [8:0] d;
      logic       fe;
      logic       pe;
      logic       dor;
   } m_ent_t;

   logic       clk;
   logic       rst_n;
   logic       rx_enable;
   logic       char_valid;
   logic [8:0] char_bits;
   logic       char_stop;
   logic       char_parity;
   logic       start_seen;
   logic [2:0] size_code;
   logic [1:0] par_mode;
   logic       rd_low;
   logic       rx_done;
   logic [7:0] rd_data;
   logic       rd_bit8;
   logic       err_frame;
   logic       err_parity;
   logic       err_overrun;

   int n_chk = 0;
   int n_bad = 0;

   m_ent_t m_q[$];
   m_ent_t m_hold;
   bit     m_hv;
   bit     m_ovr;

   rx_char_fifo #(.DEPTH(DEPTH)) i_rx_char_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_enable   (rx_enable),
      .char_valid  (char_valid),
      .char_bits   (char_bits),
      .char_stop   (char_stop),
      .char_parity (char_parity),
      .start_seen  (start_seen),
      .size_code   (size_code),
      .par_mode    (par_mode),
      .rd_low      (rd_low),
      .rx_done     (rx_done),
      .rd_data     (rd_data),
      .rd_bit8     (rd_bit8),
      .err_frame   (err_frame),
      .err_parity  (err_parity),
      .err_overrun (err_overrun)
   );

   initial begin
      clk = 1'b0;
      forever #4 clk = ~clk;
   end

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic m_ent_t cap(logic [8:0] d, logic s, logic p, logic [2:0] sz, logic [1:0] pm);
      m_ent_t r;
      int     nb;
      logic   x;
      case (sz)
         3'd0:    nb = 5;
         3'd1:    nb = 6;
         3'd2:    nb = 7;
         3'd7:    nb = 9;
         default: nb = 8;
      endcase
      r = '0;
      x = p;
      for (int b = 0; b < nb; b++) begin
         r.d[b] = d[b];
         x      = x ^ d[b];
      end
      r.fe  = !s;
      r.pe  = (pm == 2'b10) ? x : (pm == 2'b11) ? !x : 1'b0;
      r.dor = 1'b0;
      return r;
   endfunction

   // reference model, advanced on every active edge
   always @(posedge clk or negedge rst_n) begin
      bit     full, pop, mv, setov, oldov, acc;
      m_ent_t inc;
      if (!rst_n) begin
         m_q.delete();
         m_hv  = 0;
         m_ovr = 0;
         m_hold = '0;
      end else if (!rx_enable) begin
         m_q.delete();
         m_hv  = 0;
         m_ovr = 0;
      end else begin
         full  = (m_q.size() == DEPTH);
         pop   = rd_low && (m_q.size() > 0);
         mv    = m_hv && !full;
         setov = start_seen && full && m_hv && !pop;
         oldov = m_ovr;
         inc   = cap(char_bits, char_stop, char_parity, size_code, par_mode);
         acc   = char_valid && (!m_hv || mv);
         if (pop) begin
            void'(m_q.pop_front());
            if (oldov && m_q.size() > 0) m_q[0].dor = 1'b1;
         end
         if (mv) m_q.push_back(m_hold);
         m_ovr = (oldov && !pop) || setov;
         if (acc) begin
            m_hold = inc;
            m_hv   = 1;
         end else if (mv) begin
            m_hv = 0;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      m_ent_t h;
      if (rst_n) begin
         h = (m_q.size() > 0) ? m_q[0] : '0;
         chk("R2 rx_done",     16'(rx_done),     16'(m_q.size() > 0));
         chk("R1 rd_data",     16'(rd_data),     16'(h.d[7:0]));
         chk("R7 rd_bit8",     16'(rd_bit8),     16'(h.d[8]));
         chk("R3 err_frame",   16'(err_frame),   16'(h.fe));
         chk("R4 err_parity",  16'(err_parity),  16'(h.pe));
         chk("R5 err_overrun", 16'(err_overrun), 16'(h.dor));
      end
   end

   task automatic step(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic send(logic [8:0] d, logic s, logic p);
      @(negedge clk);
      char_bits   = d;
      char_stop   = s;
      char_parity = p;
      char_valid  = 1'b1;
      @(negedge clk);
      char_valid  = 1'b0;
   endtask

   task automatic read_one();
      @(negedge clk);
      rd_low = 1'b1;
      @(negedge clk);
      rd_low = 1'b0;
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_up();
   end

   initial begin
      rst_n       = 1'b0;
      rx_enable   = 1'b0;
      char_valid  = 1'b0;
      char_bits   = '0;
      char_stop   = 1'b1;
      char_parity = 1'b0;
      start_seen  = 1'b0;
      size_code   = 3'd3;
      par_mode    = 2'b00;
      rd_low      = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R2 reset rx_done", 16'(rx_done), 16'h0);
      chk("R10 reset data", 16'(rd_data), 16'h0);
      rx_enable = 1'b1;
      step(1);

      // R9 latency and R1 basic path
      send(9'h0A5, 1'b1, 1'b0);
      chk("R9 not yet visible", 16'(rx_done), 16'h0);
      step(1);
      chk("R9 visible after two edges", 16'(rx_done), 16'h1);
      chk("R1 data", 16'(rd_data), 16'h00A5);
      read_one();
      chk("R1 popped", 16'(rx_done), 16'h0);
      chk("R10 empty quiet", 16'({rd_data, rd_bit8, err_frame, err_parity, err_overrun}), 16'h0);

      // R1 read on empty queue is ignored
      read_one();
      send(9'h03C, 1'b1, 1'b0);
      step(1);
      chk("R1 empty read ignored", 16'(rd_data), 16'h003C);
      read_one();

      // R5 overrun, order, lost character
      send(9'h011, 1'b1, 1'b0);
      send(9'h022, 1'b1, 1'b0);
      send(9'h033, 1'b1, 1'b0);
      step(1);
      @(negedge clk) start_seen = 1'b1;
      @(negedge clk) start_seen = 1'b0;
      send(9'h044, 1'b1, 1'b0);
      chk("R8 head held", 16'(rd_data), 16'h0011);
      chk("R5 no flag on old head", 16'(err_overrun), 16'h0);
      read_one();
      chk("R1 order second", 16'(rd_data), 16'h0022);
      chk("R5 overrun on new head", 16'(err_overrun), 16'h1);
      step(1);
      read_one();
      chk("R9 held char drained", 16'(rd_data), 16'h0033);
      chk("R5 flag only once", 16'(err_overrun), 16'h0);
      read_one();
      chk("R5 lost char absent", 16'(rx_done), 16'h0);

      // R7 sizes
      size_code = 3'd0;
      send(9'h1FF, 1'b1, 1'b0);
      step(1);
      chk("R7 5-bit mask", 16'({rd_bit8, rd_data}), 16'h001F);
      read_one();
      size_code = 3'd1;
      send(9'h0AA, 1'b1, 1'b0);
      step(1);
      chk("R7 6-bit mask", 16'({rd_bit8, rd_data}), 16'h002A);
      read_one();
      size_code = 3'd2;
      send(9'h1FF, 1'b1, 1'b0);
      step(1);
      chk("R7 7-bit mask", 16'({rd_bit8, rd_data}), 16'h007F);
      read_one();
      size_code = 3'd5;
      send(9'h1FF, 1'b1, 1'b0);
      step(1);
      chk("R7 reserved size as 8", 16'({rd_bit8, rd_data}), 16'h00FF);
      read_one();
      size_code = 3'd7;
      send(9'h1C3, 1'b1, 1'b0);
      step(3);
      chk("R8 ninth bit held", 16'(rd_bit8), 16'h1);
      chk("R7 9-bit low byte", 16'(rd_data), 16'h00C3);
      read_one();
      chk("R8 popped on low read", 16'(rx_done), 16'h0);

      // R3 frame error
      size_code = 3'd3;
      send(9'h055, 1'b0, 1'b0);
      send(9'h056, 1'b1, 1'b0);
      step(1);
      chk("R3 frame error set", 16'(err_frame), 16'h1);
      read_one();
      chk("R3 frame error per char", 16'(err_frame), 16'h0);
      read_one();

      // R4 parity
      par_mode = 2'b10;
      send(9'h003, 1'b1, 1'b0);
      step(1);
      chk("R4 even ok", 16'(err_parity), 16'h0);
      read_one();
      send(9'h003, 1'b1, 1'b1);
      step(1);
      chk("R4 even bad", 16'(err_parity), 16'h1);
      read_one();
      par_mode = 2'b11;
      send(9'h003, 1'b1, 1'b0);
      step(1);
      chk("R4 odd bad", 16'(err_parity), 16'h1);
      read_one();
      par_mode = 2'b01;
      send(9'h003, 1'b1, 1'b1);
      step(1);
      chk("R4 reserved off", 16'(err_parity), 16'h0);
      read_one();
      par_mode = 2'b10;
      size_code = 3'd0;
      send(9'h0E0, 1'b1, 1'b0);
      step(1);
      chk("R4 parity over kept bits", 16'(err_parity), 16'h0);
      read_one();
      size_code = 3'd3;
      par_mode  = 2'b00;

      // R6 flush with overrun pending
      send(9'h061, 1'b1, 1'b0);
      send(9'h062, 1'b1, 1'b0);
      send(9'h063, 1'b1, 1'b0);
      step(1);
      @(negedge clk) start_seen = 1'b1;
      @(negedge clk) begin
         start_seen = 1'b0;
         rx_enable  = 1'b0;
         char_bits  = 9'h077;
         char_valid = 1'b1;
      end
      @(negedge clk) begin
         char_valid = 1'b0;
         rx_enable  = 1'b1;
      end
      chk("R6 flushed", 16'(rx_done), 16'h0);
      step(3);
      chk("R6 nothing survives", 16'(rx_done), 16'h0);
      send(9'h078, 1'b1, 1'b0);
      step(1);
      chk("R6 overrun discarded", 16'({rd_data, err_overrun}), 16'({8'h78, 1'b0}));
      read_one();

      // random mix, compared by the model every cycle
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         char_valid  = ($urandom_range(3) == 0);
         char_bits   = 9'($urandom);
         char_stop   = ($urandom_range(5) != 0);
         char_parity = 1'($urandom);
         start_seen  = ($urandom_range(5) == 0);
         rd_low      = ($urandom_range(4) == 0);
         rx_enable   = ($urandom_range(60) != 0);
         size_code   = 3'($urandom);
         par_mode    = 2'($urandom);
      end
      @(negedge clk);
      char_valid = 1'b0;
      start_seen = 1'b0;
      rd_low     = 1'b0;
      rx_enable  = 1'b1;
      step(3);
      finish_up();
   end

endmodule